// File: doc/BRIEF.md
# Sequential Multiply With Stack Writeback

This unit carries out the arithmetic part of an 8-bit processor's multiply instruction. The accumulator is multiplied by a memory operand, and both are treated as unsigned. The 16-bit product is split into two bytes. The low byte becomes the new accumulator value. The high byte goes out as a single stack-write request at the address the current stack pointer names. The unit then hands back the stack pointer decremented by one.

Operand fetch and the memory itself live outside the unit. A single-cycle `start` pulse captures the accumulator, the operand and the stack pointer, and `busy` rises. An internal loop adds and shifts one multiplier bit per clock. The unit then issues the write request. `done` pulses a fixed number of cycles after the start, so the instruction always takes the same time. No status flags are produced or changed.

Top module: `mul_stack_unit`

## Requirements
- R1: On the `done` cycle, `acc_out` equals the low byte of `acc_in` × `opnd_in` (unsigned), using the values captured when the start was taken.
- R2: Each operation raises `wr_en` for exactly one cycle, and `wr_data` then holds the high byte of the product.
- R3: During the write, `wr_addr` is the page constant 0x01 in bits 15:8 followed by the captured stack pointer in bits 7:0.
- R4: From the write onward, `sp_out` equals the captured stack pointer minus one, modulo 256, so 0x00 becomes 0xFF.
- R5: `done` is high for exactly one cycle, LATENCY (default 15) rising edges after the edge that took the start.
- R6: A `start` that arrives while `busy` is high is ignored. It produces no extra write and no extra `done`, and it does not change the running operation's results.
- R7: After reset, `busy`, `done` and `wr_en` are low.
- R8: Exactly one write happens per operation, while `busy` is high and before `done`.
- R9: Changes on `acc_in`, `opnd_in` and `sp_in` after the start has been taken do not affect the results.
- R10: A start given in the same cycle that `done` is high is taken, so operations can run back to back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin an operation; taken only when not busy |
| acc_in | input | 8 | Accumulator value (multiplicand) |
| opnd_in | input | 8 | Memory operand (multiplier) |
| sp_in | input | 8 | Current stack pointer |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| acc_out | output | 8 | Low product byte, new accumulator |
| sp_out | output | 8 | Decremented stack pointer |
| wr_en | output | 1 | Stack write request, one cycle |
| wr_addr | output | 16 | Stack write address |
| wr_data | output | 8 | High product byte |

## Verification
The bench builds the unit with its defaults: an 8-bit data width, a 15-cycle latency and stack page 0x01. At these sizes the full range of operands is reachable, including 0xFF × 0xFF, where the high byte is at its largest, and products with a zero operand. It also reaches the stack pointer wrap from 0x00 to 0xFF and the fixed completion time. With that latency, a second start can be placed well inside the busy window, and another can land on the `done` cycle itself.

// File: rtl/mulstk_pkg.sv
package mulstk_pkg;
  localparam int DEF_DATA_W  = 8;
  localparam int DEF_LATENCY = 15;

  function automatic int cnt_width(input int latency);
    return (latency < 2) ? 1 : $clog2(latency);
  endfunction
endpackage

// File: rtl/mulstk_seq.sv
module mulstk_seq #(
  parameter int DATA_W  = mulstk_pkg::DEF_DATA_W,
  parameter int LATENCY = mulstk_pkg::DEF_LATENCY
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  output logic load,
  output logic step,
  output logic wr_go,
  output logic busy,
  output logic done
);
  localparam int CW = mulstk_pkg::cnt_width(LATENCY);
  localparam logic [CW-1:0] LAST   = CW'(LATENCY - 1);
  localparam logic [CW-1:0] NSTEPS = CW'(DATA_W);

  logic [CW-1:0] cnt;

  assign load  = start && !busy;
  assign step  = busy && (cnt < NSTEPS);
  assign wr_go = busy && (cnt == NSTEPS);

  always_ff @(posedge clk) begin
    if (rst) begin
      busy <= 1'b0;
      done <= 1'b0;
      cnt  <= '0;
    end else begin
      done <= 1'b0;
      if (!busy) begin
        if (start) begin
          busy <= 1'b1;
          cnt  <= '0;
        end
      end else begin
        cnt <= cnt + 1'b1;
        if (cnt == LAST) begin
          busy <= 1'b0;
          done <= 1'b1;
        end
      end
    end
  end

  // R5: completion is a single-cycle pulse
  assert_done_pulse_R5: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R6: a start during an operation does not disturb the busy window
  assert_start_ignored_R6: assert property (@(posedge clk) disable iff (rst)
    (busy && start && cnt != LAST) |=> (busy && cnt == $past(cnt) + 1'b1));
endmodule

// File: rtl/mulstk_core.sv
module mulstk_core #(
  parameter int DATA_W = mulstk_pkg::DEF_DATA_W
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  load,
  input  logic                  step,
  input  logic [DATA_W-1:0]     mcand,
  input  logic [DATA_W-1:0]     mplier,
  output logic [2*DATA_W-1:0]   prod
);
  logic [DATA_W-1:0] mcand_r;
  logic [DATA_W:0]   partial;

  // Add the multiplicand into the upper half when the current low bit is set.
  assign partial = {1'b0, prod[2*DATA_W-1:DATA_W]} +
                   {1'b0, (prod[0] ? mcand_r : {DATA_W{1'b0}})};

  always_ff @(posedge clk) begin
    if (rst) begin
      mcand_r <= '0;
      prod    <= '0;
    end else if (load) begin
      mcand_r <= mcand;
      prod    <= {{DATA_W{1'b0}}, mplier};
    end else if (step) begin
      prod    <= {partial, prod[DATA_W-1:1]};
    end
  end

  // R9: the product register holds while no load or step is requested
  assert_hold_R9: assert property (@(posedge clk) disable iff (rst)
    (!load && !step) |=> $stable(prod));
endmodule

// File: rtl/mulstk_wb.sv
module mulstk_wb #(
  parameter int                 DATA_W     = mulstk_pkg::DEF_DATA_W,
  parameter logic [DATA_W-1:0]  STACK_PAGE = 8'h01
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  load,
  input  logic                  wr_go,
  input  logic [DATA_W-1:0]     sp_in,
  input  logic [2*DATA_W-1:0]   prod,
  output logic [DATA_W-1:0]     acc_out,
  output logic [DATA_W-1:0]     sp_out,
  output logic                  wr_en,
  output logic [2*DATA_W-1:0]   wr_addr,
  output logic [DATA_W-1:0]     wr_data
);
  logic [DATA_W-1:0] sp_cap;

  always_ff @(posedge clk) begin
    if (rst) begin
      sp_cap  <= '0;
      acc_out <= '0;
      sp_out  <= '0;
      wr_en   <= 1'b0;
      wr_addr <= '0;
      wr_data <= '0;
    end else begin
      wr_en <= 1'b0;
      if (load) sp_cap <= sp_in;
      if (wr_go) begin
        wr_en   <= 1'b1;
        wr_addr <= {STACK_PAGE, sp_cap};
        wr_data <= prod[2*DATA_W-1:DATA_W];
        acc_out <= prod[DATA_W-1:0];
        sp_out  <= sp_cap - DATA_W'(1);
      end
    end
  end

  // R2: the write request lasts one cycle
  assert_wr_single_R2: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> !wr_en);

  // R4: the returned pointer sits one below the written slot
  assert_sp_dec_R4: assert property (@(posedge clk) disable iff (rst)
    wr_en |-> (sp_out == wr_addr[DATA_W-1:0] - DATA_W'(1)));

  // R3: the write goes to the stack page
  assert_page_R3: assert property (@(posedge clk) disable iff (rst)
    wr_en |-> (wr_addr[2*DATA_W-1:DATA_W] == STACK_PAGE));
endmodule

// File: rtl/mul_stack_unit.sv
module mul_stack_unit #(
  parameter int                 DATA_W     = mulstk_pkg::DEF_DATA_W,
  parameter int                 LATENCY    = mulstk_pkg::DEF_LATENCY,
  parameter logic [DATA_W-1:0]  STACK_PAGE = 8'h01
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  start,
  input  logic [DATA_W-1:0]     acc_in,
  input  logic [DATA_W-1:0]     opnd_in,
  input  logic [DATA_W-1:0]     sp_in,
  output logic                  busy,
  output logic                  done,
  output logic [DATA_W-1:0]     acc_out,
  output logic [DATA_W-1:0]     sp_out,
  output logic                  wr_en,
  output logic [2*DATA_W-1:0]   wr_addr,
  output logic [DATA_W-1:0]     wr_data
);
  logic                 load, step, wr_go;
  logic [2*DATA_W-1:0]  prod;

  mulstk_seq #(.DATA_W(DATA_W), .LATENCY(LATENCY)) u_seq (
    .clk(clk), .rst(rst), .start(start),
    .load(load), .step(step), .wr_go(wr_go),
    .busy(busy), .done(done)
  );

  mulstk_core #(.DATA_W(DATA_W)) u_core (
    .clk(clk), .rst(rst), .load(load), .step(step),
    .mcand(acc_in), .mplier(opnd_in), .prod(prod)
  );

  mulstk_wb #(.DATA_W(DATA_W), .STACK_PAGE(STACK_PAGE)) u_wb (
    .clk(clk), .rst(rst), .load(load), .wr_go(wr_go),
    .sp_in(sp_in), .prod(prod),
    .acc_out(acc_out), .sp_out(sp_out),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data)
  );

  // R8: the stack write happens inside the busy window
  assert_wr_in_busy_R8: assert property (@(posedge clk) disable iff (rst)
    wr_en |-> (busy && !done));

  // R7: nothing is signalled out of reset
  assert_reset_quiet_R7: assert property (@(posedge clk)
    rst |=> (!busy && !done && !wr_en));
endmodule

// File: tb/mul_stack_unit_test.sv
module mul_stack_unit_test;
  localparam int W   = 8;
  localparam int LAT = 15;

  typedef struct {
    logic [W-1:0]   acc;
    logic [W-1:0]   sp;
    logic [W-1:0]   hi;
    logic [2*W-1:0] addr;
    int             t0;
  } exp_t;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0;
  logic [W-1:0] acc_in = '0, opnd_in = '0, sp_in = '0;
  logic busy, done, wr_en;
  logic [W-1:0] acc_out, sp_out, wr_data;
  logic [2*W-1:0] wr_addr;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  int writes = 0;
  bit finished = 1'b0;
  exp_t q[$];
  logic [W-1:0] stk [0:255];

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  mul_stack_unit uut (
    .clk(clk), .rst(rst), .start(start),
    .acc_in(acc_in), .opnd_in(opnd_in), .sp_in(sp_in),
    .busy(busy), .done(done), .acc_out(acc_out), .sp_out(sp_out),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Driver: waits until idle, pulses start, pushes the expected result.
  task automatic run_op(input logic [W-1:0] a, input logic [W-1:0] b, input logic [W-1:0] sp,
                        input bit poke);
    exp_t e;
    logic [2*W-1:0] p;
    while (busy) @(negedge clk);
    acc_in = a; opnd_in = b; sp_in = sp; start = 1'b1;
    @(posedge clk);
    @(negedge clk);
    p = 16'(a) * 16'(b);
    e.acc = p[7:0]; e.hi = p[15:8]; e.sp = sp - 8'd1;
    e.addr = {8'h01, sp}; e.t0 = cyc;
    q.push_back(e);
    start = 1'b0;
    // R9: scramble the inputs while the operation runs
    acc_in = ~a; opnd_in = b ^ 8'h5A; sp_in = sp + 8'd7;
    if (poke) begin
      repeat (4) @(negedge clk);
      // R6: a start while busy must be ignored
      start = 1'b1; acc_in = 8'h33; opnd_in = 8'h77; sp_in = 8'h10;
      @(negedge clk);
      start = 1'b0;
    end
  endtask

  // Monitor: pops expectations as writes and completions appear.
  always @(negedge clk) begin
    if (!rst) begin
      if (wr_en) begin
        writes++;
        if (q.size() == 0) chk(1'b0, "R6 unexpected write", 1, 0);
        else begin
          chk(wr_addr == q[0].addr, "R3 wr_addr", wr_addr, q[0].addr);
          chk(wr_data == q[0].hi, "R2 wr_data", wr_data, q[0].hi);
          chk(busy, "R8 write while busy", busy, 1);
        end
        stk[wr_addr[7:0]] <= wr_data;
      end
      if (done) begin
        if (q.size() == 0) chk(1'b0, "R6 unexpected done", 1, 0);
        else begin
          exp_t e;
          e = q.pop_front();
          chk(acc_out == e.acc, "R1 acc_out", acc_out, e.acc);
          chk(sp_out == e.sp, "R4 sp_out", sp_out, e.sp);
          chk(cyc - e.t0 == LAT, "R5 latency", cyc - e.t0, LAT);
          chk(writes == 1, "R8 one write", writes, 1);
          chk(stk[e.addr[7:0]] == e.hi, "R2 stack model", stk[e.addr[7:0]], e.hi);
          chk(!busy, "R5 idle at done", busy, 0);
        end
        writes = 0;
      end
    end
  end

  // R5: done must not stay high
  always @(negedge clk) begin
    if (!rst && done) begin
      @(negedge clk);
      chk(!done, "R5 done one cycle", done, 0);
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R7: reset state
    chk(!busy, "R7 busy", busy, 0);
    chk(!done, "R7 done", done, 0);
    chk(!wr_en, "R7 wr_en", wr_en, 0);

    run_op(8'hFF, 8'hFF, 8'h80, 1'b0);
    run_op(8'h00, 8'hC3, 8'h40, 1'b0);
    run_op(8'h9D, 8'h00, 8'hFF, 1'b0);
    run_op(8'h01, 8'h01, 8'h00, 1'b0);   // R4: pointer wrap 00 -> FF
    run_op(8'h80, 8'h02, 8'h12, 1'b1);   // R6: start poked mid-run
    run_op(8'h0F, 8'h11, 8'h01, 1'b1);
    // R10: back to back, next start lands on the done cycle
    for (int i = 0; i < 24; i++)
      run_op(8'($urandom), 8'($urandom), 8'($urandom), (i % 5) == 0);
    while (busy || q.size() != 0) @(negedge clk);
    repeat (20) @(negedge clk);
    chk(q.size() == 0, "R6 no pending", q.size(), 0);
    chk(!busy && !wr_en, "R6 quiet after ignored starts", busy, 0);
    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule